// File: doc/BRIEF.md
# LED Blink Generator with Auto-Stop

This block drives one LED with a programmable blink pattern. A prescaler divides the input clock by a power of two and produces a tick. A period counter advances once per tick and restarts after a programmed number of ticks. The LED is lit for the first part of each period and dark for the rest, which gives a duty-cycle blink. Four word registers on a simple synchronous write bus with a combinational read port set the speed, the period, the on-time and an optional stop count.

With auto-stop armed, every completed period uses up one unit of a live stop count. The period that uses up the last unit switches the generator off and sets a sticky event flag. That flag raises an interrupt request unless a mask bit blocks it. Software clears the flag with a write-one-to-clear bit in the control word.

Top module: `led_blinker`

## Requirements
- R1: After reset every register reads zero, `led_o` is 0 and `irq_o` is 0.
- R2: `bus_addr[3:2]` selects the word: 0 control, 1 period (12 bits), 2 on-time (12 bits), 3 stop count (16 bits). Control bits are rate [3:0], run [4], auto-stop [5], interrupt mask [6]. A read of the control word returns the sticky stop flag in bit 7. Unused bits read 0, and a read of word 3 returns the live remaining count.
- R3: While running, the counter advances once every 2^(13 - rate) clocks. Rate values above 13 behave as 13, which advances the counter on every clock.
- R4: The counter runs from 0 to period-1 and then wraps. A period of 0 behaves as 1. `led_o` is 1 exactly while run is set and the counter is below the on-time, so on-time 0 is always dark and on-time >= period is always lit.
- R5: With run clear, `led_o` is 0 and the counter is held at 0.
- R6: Any write to the control, period or on-time word restarts the counter and the prescaler from zero.
- R7: With auto-stop set, each wrap decrements the remaining count. A wrap that finds the count at 1 or 0 clears run, sets the count to 0, turns the LED off and sets the stop flag.
- R8: `irq_o` equals the stop flag AND NOT the mask bit. A control write with bit 7 set clears the flag, and a control write with bit 7 clear leaves it unchanged.
- R9: With auto-stop clear, blinking continues indefinitely and the remaining count does not change.
- R10: A write to the control, period or on-time word in the same cycle as a wrap cancels that wrap: no decrement and no stop. A control write also reloads the remaining count from the stop count word. A write to word 3 loads both the stop count and the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| led_o | output | 1 | LED drive, 1 = lit |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A bus write and a period wrap can land on the same clock edge. The contested cases are a wrap that would use up the last stop unit, met by an on-time write or by a control write. The bench counts clock edges from the enabling write and places the competing write on the exact edge of the wrap. It then reads back the run bit, the stop flag and the remaining count to confirm that the write won. It also checks that blinking resumes and stops again one full period later, on the edge the arithmetic predicts.

// File: rtl/led_blinker.sv
module led_blinker #(
  parameter int MAX_SHIFT = 13,
  parameter int PER_W     = 12,
  parameter int CNT_W     = 16,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          led_o,
  output logic          irq_o
);
  localparam int RW    = 4;
  localparam int PRE_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [RW-1:0]    rate_q;
  logic             run_q, auto_q, mask_q, flag_q;
  logic [PER_W-1:0] period_q, ontime_q, cnt_q;
  logic [CNT_W-1:0] stop_q, left_q;
  logic [PRE_W-1:0] pre_q;

  logic wr_ctl, wr_per, wr_on, wr_stop;
  assign wr_ctl  = bus_we && bus_addr[3:2] == 2'd0;
  assign wr_per  = bus_we && bus_addr[3:2] == 2'd1;
  assign wr_on   = bus_we && bus_addr[3:2] == 2'd2;
  assign wr_stop = bus_we && bus_addr[3:2] == 2'd3;

  logic [RW-1:0]    rate_eff;
  logic [PRE_W-1:0] pre_mask;
  logic [PER_W-1:0] last;
  logic tick, wrap, last_unit;

  assign rate_eff  = (int'(rate_q) > MAX_SHIFT) ? RW'(MAX_SHIFT) : rate_q;
  assign pre_mask  = ~({PRE_W{1'b1}} << (RW'(MAX_SHIFT) - rate_eff));
  assign tick      = run_q && ((pre_q & pre_mask) == pre_mask);
  assign last      = (period_q == '0) ? '0 : period_q - 1'b1;
  assign wrap      = tick && (cnt_q >= last);
  assign last_unit = (left_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0; run_q <= 1'b0; auto_q <= 1'b0; mask_q <= 1'b0; flag_q <= 1'b0;
      period_q <= '0; ontime_q <= '0; stop_q <= '0; left_q <= '0;
      cnt_q <= '0; pre_q <= '0;
    end else if (wr_ctl) begin
      rate_q <= bus_wdata[3:0];
      run_q  <= bus_wdata[4];
      auto_q <= bus_wdata[5];
      mask_q <= bus_wdata[6];
      if (bus_wdata[7]) flag_q <= 1'b0;
      left_q <= stop_q;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else if (wr_per || wr_on) begin
      if (wr_per) period_q <= bus_wdata[PER_W-1:0];
      if (wr_on)  ontime_q <= bus_wdata[PER_W-1:0];
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (run_q) begin
        pre_q <= pre_q + 1'b1;
        if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        if (wrap && auto_q) begin
          if (last_unit) begin
            run_q  <= 1'b0;
            flag_q <= 1'b1;
            left_q <= '0;
            cnt_q  <= '0;
            pre_q  <= '0;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
      end
      if (wr_stop) begin
        stop_q <= bus_wdata[CNT_W-1:0];
        left_q <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  assign led_o = run_q && (cnt_q < ontime_q);
  assign irq_o = flag_q && !mask_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr[3:2])
      2'd0:    bus_rdata[7:0] = {flag_q, mask_q, auto_q, run_q, rate_q};
      2'd1:    bus_rdata[PER_W-1:0] = period_q;
      2'd2:    bus_rdata[PER_W-1:0] = ontime_q;
      default: bus_rdata[CNT_W-1:0] = left_q;
    endcase
  end
endmodule

// File: rtl/led_blinker_chk.sv
module led_blinker_chk #(
  parameter int PER_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             run,
  input logic             auto_stop,
  input logic             mask,
  input logic             flag,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] period,
  input logic [CNT_W-1:0] left,
  input logic             led_o,
  input logic             irq_o
);
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n) !run |-> (!led_o && cnt == '0)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cnt == '0) || (cnt < period)); // R4
  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> (!run && !led_o && left == '0)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) mask |-> !irq_o); // R8
  AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (run && !auto_stop && !bus_we) |=> $stable(left)); // R9
endmodule

bind led_blinker led_blinker_chk #(.PER_W(PER_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .run(run_q), .auto_stop(auto_q),
  .mask(mask_q), .flag(flag_q), .cnt(cnt_q), .period(period_q), .left(left_q),
  .led_o(led_o), .irq_o(irq_o)
);

// File: tb/led_blinker_test.sv
`timescale 1ns/1ps
module led_blinker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        led_o, irq_o;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  led_blinker uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_o(led_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1", "led", led_o, 0);
    chk("R1", "irq", irq_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), r);
      chk("R1", "reg", r, 0);
    end

    // R2 readback and field widths
    wr(4'h4, 16'hFABC); rd(4'h4, r); chk("R2", "period width", r, 16'h0ABC);
    wr(4'h8, 16'h1234); rd(4'h8, r); chk("R2", "ontime width", r, 16'h0234);
    wr(4'hC, 16'hBEEF); rd(4'hC, r); chk("R2", "count", r, 16'hBEEF);
    wr(4'h0, 16'hFF45); rd(4'h0, r); chk("R2", "control", r, 16'h0045);
    wr(4'h0, 16'h0000);

    // R4 sweep of period and on-time at full rate
    for (int p = 0; p < 6; p++) begin
      for (int d = 0; d < 7; d++) begin
        int pe;
        pe = (p == 0) ? 1 : p;
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'(p));
        wr(4'h8, 16'(d));
        wr(4'h0, 16'h001D);
        for (int k = 0; k < 12; k++) begin
          chk("R4", "led pattern", led_o, ((k % pe) < d) ? 1 : 0);
          step();
        end
      end
    end

    // R5 disabled stays dark
    wr(4'h4, 16'd4); wr(4'h8, 16'd9); wr(4'h0, 16'h000D);
    for (int k = 0; k < 5; k++) begin
      chk("R5", "led when off", led_o, 0);
      step();
    end

    // R6 on-time write restarts the counter
    wr(4'h8, 16'd2); wr(4'h0, 16'h001D);
    step(); step();
    chk("R6", "before restart", led_o, 0);
    wr(4'h8, 16'd2);
    chk("R6", "restart k0", led_o, 1);
    step(); chk("R6", "restart k1", led_o, 1);
    step(); chk("R6", "restart k2", led_o, 0);

    // R3 rate sweep with clamping
    wr(4'h0, 16'h0000); wr(4'h4, 16'd2); wr(4'h8, 16'd1);
    for (int tb = 9; tb < 16; tb++) begin
      int s;
      s = 13 - ((tb > 13) ? 13 : tb);
      wr(4'h0, 16'(16'h10 | tb));
      for (int k = 0; k < (4 << s); k++) begin
        chk("R3", "tick rate", led_o, (((k >> s) % 2) < 1) ? 1 : 0);
        step();
      end
    end

    // R7 auto-stop after three periods
    wr(4'h0, 16'h0000); wr(4'h4, 16'd3); wr(4'h8, 16'd2); wr(4'hC, 16'd3);
    wr(4'h0, 16'h003D);
    for (int k = 0; k < 9; k++) begin
      chk("R7", "led while counting", led_o, ((k % 3) < 2) ? 1 : 0);
      chk("R7", "irq while counting", irq_o, 0);
      if (k == 4) begin
        rd(4'hC, r); chk("R7", "remaining", r, 2);
      end
      step();
    end
    chk("R7", "led after stop", led_o, 0);
    chk("R8", "irq after stop", irq_o, 1);
    rd(4'h0, r); chk("R7", "control after stop", r, 16'h00AD);
    rd(4'hC, r); chk("R7", "remaining after stop", r, 0);
    step(); step();
    chk("R7", "led stays off", led_o, 0);

    // R8 mask and clear
    wr(4'h0, 16'h004D); chk("R8", "masked irq", irq_o, 0);
    rd(4'h0, r); chk("R8", "flag kept", r[7], 1);
    wr(4'h0, 16'h000D); chk("R8", "unmasked irq", irq_o, 1);
    wr(4'h0, 16'h008D); chk("R8", "cleared irq", irq_o, 0);
    rd(4'h0, r); chk("R8", "flag cleared", r[7], 0);

    // R9 no auto-stop keeps running
    wr(4'h4, 16'd2); wr(4'h8, 16'd1); wr(4'hC, 16'd2); wr(4'h0, 16'h001D);
    for (int k = 0; k < 10; k++) begin
      chk("R9", "free blink", led_o, ((k % 2) < 1) ? 1 : 0);
      step();
    end
    rd(4'hC, r); chk("R9", "count unchanged", r, 2);
    rd(4'h0, r); chk("R9", "still running", r[4], 1);

    // R10 on-time write on the final wrap edge
    wr(4'h0, 16'h0000); wr(4'hC, 16'd2); wr(4'h0, 16'h003D);
    step(); step(); step();
    wr(4'h8, 16'd1);
    rd(4'h0, r); chk("R10", "run kept", r[4], 1);
    chk("R10", "flag not set", r[7], 0);
    rd(4'hC, r); chk("R10", "remaining kept", r, 1);
    step();
    chk("R10", "irq before stop", irq_o, 0);
    step();
    chk("R10", "irq after stop", irq_o, 1);
    rd(4'h0, r); chk("R10", "run cleared", r[4], 0);

    // R10 control write on the final wrap edge
    wr(4'h0, 16'h0080); wr(4'hC, 16'd1); wr(4'h0, 16'h003D);
    step();
    wr(4'h0, 16'h003D);
    rd(4'h0, r); chk("R10", "ctrl wins run", r[4], 1);
    chk("R10", "ctrl wins flag", r[7], 0);
    rd(4'hC, r); chk("R10", "reloaded", r, 1);
    step(); step();
    chk("R10", "later stop irq", irq_o, 1);
    chk("R10", "later stop led", led_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule